// File: doc/BRIEF.md
# Run-Mode Clock Source Controller

This controller decides whether a small microcontroller core runs from its primary oscillator or from the internal RC path. It drives the enables of the primary oscillator, the internal fast oscillator and the slow internal RC oscillator. It reports which source is active, and it keeps two status flags. The first flag says the primary clock is stable and in use. The second says the internal fast output has settled. The glitch-free clock multiplexer and the oscillators are not part of this block. Each oscillator is represented by an enable, and the primary start-up is represented by a ready pulse that comes back from outside.

The controller is a four-state machine. After reset it is in `ST_PRI_START`: the primary oscillator is enabled and the block waits for its ready pulse. `ST_PRI_RUN` means the primary clock is stable and drives the core. `ST_RC_RUN` means the core runs from the internal path and the primary oscillator is shut down. `ST_RC_TO_PRI` means the core still runs from the internal path while the primary oscillator restarts.

The transitions are as follows:
- `enter_rc`: from either primary state to `ST_RC_RUN`, taken when the upper select bit is set.
- `pri_settled`: from `ST_PRI_START` to `ST_PRI_RUN`, taken on the ready pulse.
- `leave_rc`: from `ST_RC_RUN` to `ST_RC_TO_PRI`, taken when the upper select bit clears.
- `abort_return`: from `ST_RC_TO_PRI` back to `ST_RC_RUN`, taken when the upper select bit is set again.
- `switch_done`: from `ST_RC_TO_PRI` to `ST_PRI_RUN`, taken on the ready pulse.

A separate tracker times the settling of the internal fast oscillator with a down-counter.

Top module: `clk_src_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) gives the following state: `active_src`=2'b00 (primary), `pri_osc_en`=1, `pri_ok`=0 and `fast_ok`=0. Until the first `pri_rdy` pulse, `pri_ok` stays 0.
- R2: In the start-up state, a `pri_rdy` pulse sets `pri_ok` at that clock edge. `active_src` stays 2'b00.
- R3: When `src_sel[1]` is 1 at an edge in either primary state, the block enters internal run at that edge, whatever the value of `src_sel[0]`. After that edge `active_src`=2'b01 (internal), `pri_osc_en`=0 and `pri_ok`=0.
- R4: In internal modes, `int_freq` follows `ifreq_sel` in the same cycle with no clock edge. In primary modes, `int_freq` is 0.
- R5: In internal modes, when `ifreq_sel`=0 and `int_src`=0, `fast_osc_en` stays 0 and `fast_ok` stays 0, however long the block waits.
- R6: When the fast request rises (internal mode with `ifreq_sel`≠0 or `int_src`=1), `fast_osc_en` is 1 at once. `fast_ok` stays 0 for STAB_CYCLES-1 edges and becomes 1 at the STAB_CYCLES-th edge. The core clock keeps running during this interval.
- R7: While the fast request stays high, `fast_ok` stays 1 with no new wait. This holds when `ifreq_sel` changes between non-zero values and when the block moves between `ST_RC_RUN` and `ST_RC_TO_PRI`.
- R8: When `src_sel[1]` clears in internal run, `pri_osc_en` becomes 1 and `active_src` stays 2'b01 until a `pri_rdy` pulse. At that pulse's edge, `active_src` becomes 2'b00, `pri_ok` becomes 1, and `fast_ok` and `fast_osc_en` become 0. `pri_ok` and `fast_ok` are never 1 together.
- R9: A `pri_rdy` pulse in `ST_RC_RUN` is ignored: `active_src`, `pri_osc_en` and `pri_ok` do not change.
- R10: `slow_rc_en` is 1 in internal modes. In primary modes it equals `wdog_en | clkmon_en`.
- R11: If `src_sel[1]` is set again in `ST_RC_TO_PRI`, the block returns to `ST_RC_RUN` with `pri_osc_en`=0. This takes priority over a `pri_rdy` pulse at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Source select; bit 1 set requests internal run |
| ifreq_sel | input | 3 | Internal frequency select; 0 means no fast output |
| int_src | input | 1 | Requests the fast internal source |
| pri_rdy | input | 1 | Primary oscillator ready pulse |
| wdog_en | input | 1 | Watchdog enabled |
| clkmon_en | input | 1 | Clock monitor enabled |
| active_src | output | 2 | 00 primary, 01 internal path |
| pri_osc_en | output | 1 | Primary oscillator enable |
| fast_osc_en | output | 1 | Internal fast oscillator enable |
| slow_rc_en | output | 1 | Slow internal RC enable |
| int_freq | output | 3 | Internal frequency in effect |
| pri_ok | output | 1 | Primary clock stable and in use |
| fast_ok | output | 1 | Internal fast output stable |

## Verification
The bench builds the block with STAB_CYCLES=5. This keeps the whole settling window short, so the edge just before the flag rises and the edge where it rises can both be sampled directly. The short window also lets a fast-ready wait sit inside a return to primary and an aborted return. The bench runs both the table walk and the directed checks against this one configuration.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
    typedef enum logic [1:0] {
        ST_PRI_START = 2'd0,
        ST_PRI_RUN   = 2'd1,
        ST_RC_RUN    = 2'd2,
        ST_RC_TO_PRI = 2'd3
    } ccs_state_e;

    localparam logic [1:0] SRC_PRI = 2'b00;
    localparam logic [1:0] SRC_INT = 2'b01;
endpackage

// File: rtl/ccs_fsm.sv
module ccs_fsm
    import ccs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       src_hi,
    input  logic       pri_rdy,
    output logic       int_mode,
    output logic [1:0] active_src,
    output logic       pri_osc_en,
    output logic       pri_ok,
    output logic       switch_done
);
    ccs_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_PRI_START: if (src_hi) nxt = ST_RC_RUN; else if (pri_rdy) nxt = ST_PRI_RUN;
            ST_PRI_RUN:   if (src_hi) nxt = ST_RC_RUN;
            ST_RC_RUN:    if (!src_hi) nxt = ST_RC_TO_PRI;
            ST_RC_TO_PRI: if (src_hi) nxt = ST_RC_RUN; else if (pri_rdy) nxt = ST_PRI_RUN;
            default:      nxt = ST_PRI_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_PRI_START;
        else     state <= nxt;
    end

    always_comb begin
        int_mode    = 1'b0;
        active_src  = SRC_PRI;
        pri_osc_en  = 1'b1;
        pri_ok      = 1'b0;
        switch_done = 1'b0;
        unique case (state)
            ST_PRI_START: ;
            ST_PRI_RUN:   pri_ok = 1'b1;
            ST_RC_RUN: begin
                int_mode   = 1'b1;
                active_src = SRC_INT;
                pri_osc_en = 1'b0;
            end
            ST_RC_TO_PRI: begin
                int_mode    = 1'b1;
                active_src  = SRC_INT;
                switch_done = !src_hi && pri_rdy;
            end
            default: ;
        endcase
    end

    // R3: a raised upper select bit leaves the primary states at the next edge
    p_enter_rc_r3: assert property (@(posedge clk) disable iff (rst)
        (!int_mode && src_hi) |=> (active_src == SRC_INT && !pri_osc_en && !pri_ok));
    // R8: the internal path stays active until the primary reports ready
    p_hold_int_r8: assert property (@(posedge clk) disable iff (rst)
        (int_mode && !pri_rdy) |=> (active_src == SRC_INT));
    // R11: a re-raised select beats a simultaneous ready pulse
    p_abort_r11: assert property (@(posedge clk) disable iff (rst)
        (int_mode && src_hi) |=> (int_mode && !pri_osc_en));
endmodule

// File: rtl/ccs_fast_tracker.sv
module ccs_fast_tracker #(
    parameter int STAB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fast_req,
    input  logic clr,
    output logic fast_ok
);
    localparam int CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(STAB_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || !fast_req) begin
            cnt     <= CNT_INIT;
            fast_ok <= 1'b0;
        end else if (!fast_ok) begin
            if (cnt <= CW'(1)) fast_ok <= 1'b1;
            else               cnt     <= cnt - CW'(1);
        end
    end

    // R5: no request means the ready flag is cleared at the next edge
    p_no_req_r5: assert property (@(posedge clk) disable iff (rst)
        !fast_req |=> !fast_ok);
    // R6: the ready flag only rises after a cycle with the request present
    p_rise_req_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fast_ok) |-> $past(fast_req));
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl #(
    parameter int STAB_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src_sel,
    input  logic [2:0] ifreq_sel,
    input  logic       int_src,
    input  logic       pri_rdy,
    input  logic       wdog_en,
    input  logic       clkmon_en,
    output logic [1:0] active_src,
    output logic       pri_osc_en,
    output logic       fast_osc_en,
    output logic       slow_rc_en,
    output logic [2:0] int_freq,
    output logic       pri_ok,
    output logic       fast_ok
);
    logic int_mode;
    logic switch_done;
    logic fast_req;
    logic unused_src_lo;

    assign unused_src_lo = src_sel[0];

    ccs_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .src_hi      (src_sel[1]),
        .pri_rdy     (pri_rdy),
        .int_mode    (int_mode),
        .active_src  (active_src),
        .pri_osc_en  (pri_osc_en),
        .pri_ok      (pri_ok),
        .switch_done (switch_done)
    );

    assign fast_req    = int_mode && ((|ifreq_sel) || int_src);
    assign fast_osc_en = fast_req;
    assign int_freq    = int_mode ? ifreq_sel : 3'd0;
    assign slow_rc_en  = int_mode || wdog_en || clkmon_en;

    ccs_fast_tracker #(.STAB_CYCLES(STAB_CYCLES)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .fast_req (fast_req),
        .clr      (switch_done),
        .fast_ok  (fast_ok)
    );

    // R8: the two status flags never show together
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(pri_ok && fast_ok));
    // R1: primary-ready needs a ready pulse in the cycle before it rises
    p_pri_needs_rdy_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(pri_ok) |-> $past(pri_rdy));
endmodule

// File: tb/clk_src_ctrl_bench.sv
module clk_src_ctrl_bench;
    localparam int STAB = 5;
    localparam int NROW = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] src_sel = 2'b00;
    logic [2:0] ifreq_sel = 3'd0;
    logic int_src = 1'b0, pri_rdy = 1'b0, wdog_en = 1'b0, clkmon_en = 1'b0;
    logic [1:0] active_src;
    logic pri_osc_en, fast_osc_en, slow_rc_en, pri_ok, fast_ok;
    logic [2:0] int_freq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    clk_src_ctrl #(.STAB_CYCLES(STAB)) u_clk_src_ctrl (
        .clk(clk), .rst(rst), .src_sel(src_sel), .ifreq_sel(ifreq_sel),
        .int_src(int_src), .pri_rdy(pri_rdy), .wdog_en(wdog_en),
        .clkmon_en(clkmon_en), .active_src(active_src), .pri_osc_en(pri_osc_en),
        .fast_osc_en(fast_osc_en), .slow_rc_en(slow_rc_en), .int_freq(int_freq),
        .pri_ok(pri_ok), .fast_ok(fast_ok)
    );

    // stimulus {src_sel, ifreq_sel, int_src, pri_rdy, wdog_en, clkmon_en}
    localparam logic [8:0] STIM [NROW] = '{
        9'b00_000_0_0_0_0, 9'b00_000_0_1_0_0, 9'b00_000_0_0_1_0, 9'b00_000_0_0_0_1,
        9'b10_000_0_0_0_0, 9'b10_000_0_1_0_0, 9'b00_000_0_0_0_0, 9'b00_000_0_1_0_0,
        9'b11_000_0_0_0_0, 9'b01_011_0_0_0_0, 9'b10_011_0_1_0_0, 9'b10_000_1_0_0_0,
        9'b00_000_0_0_0_0, 9'b00_000_0_1_0_0};
    // expected after the edge {active_src, pri_osc_en, pri_ok, fast_osc_en, slow_rc_en}
    localparam logic [5:0] EXPV [NROW] = '{
        6'b00_1_0_0_0, 6'b00_1_1_0_0, 6'b00_1_1_0_1, 6'b00_1_1_0_1,
        6'b01_0_0_0_1, 6'b01_0_0_0_1, 6'b01_1_0_0_1, 6'b00_1_1_0_0,
        6'b01_0_0_0_1, 6'b01_1_0_1_1, 6'b01_0_0_1_1, 6'b01_0_0_1_1,
        6'b01_1_0_0_1, 6'b00_1_1_0_0};
    localparam string TAG [NROW] = '{
        "R1", "R2", "R10", "R10", "R3", "R9", "R8", "R8",
        "R3", "R6", "R11", "R6", "R8", "R8"};

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [8:0] v);
        @(negedge clk);
        {src_sel, ifreq_sel, int_src, pri_rdy, wdog_en, clkmon_en} = v;
    endtask

    function automatic logic [5:0] obs();
        return {active_src, pri_osc_en, pri_ok, fast_osc_en, slow_rc_en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", {active_src, pri_osc_en, pri_ok, fast_ok}, {2'b00, 1'b1, 1'b0, 1'b0});
        chk("R4", int_freq, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NROW; i++) begin
            drive(STIM[i]);
            tick();
            chk(TAG[i], obs(), EXPV[i]);
        end

        // R4 primary mode masks the frequency field
        drive(9'b00_110_0_0_0_0);
        #1;
        chk("R4", int_freq, 0);

        // R6 settling window from primary run
        drive(9'b10_101_0_0_0_0);
        tick();
        chk("R6", {fast_osc_en, fast_ok}, 2'b10);
        chk("R4", int_freq, 5);
        repeat (STAB - 1) tick();
        chk("R6", fast_ok, 0);
        tick();
        chk("R6", fast_ok, 1);

        // R4 frequency change seen without an edge; R7 flag kept
        drive(9'b10_010_0_0_0_0);
        #1;
        chk("R4", int_freq, 2);
        tick();
        chk("R7", fast_ok, 1);

        // R7 return started then aborted keeps the flag
        drive(9'b00_010_0_0_0_0);
        tick();
        chk("R7", {active_src, pri_osc_en, fast_ok}, {2'b01, 1'b1, 1'b1});
        drive(9'b10_010_0_0_0_0);
        tick();
        chk("R7", {pri_osc_en, fast_ok}, 2'b01);

        // R8 internal path held while primary starts, then switch completes
        drive(9'b00_010_0_0_0_0);
        tick();
        repeat (3) tick();
        chk("R8", {active_src, pri_ok, fast_ok}, {2'b01, 1'b0, 1'b1});
        drive(9'b00_010_0_1_0_0);
        #1;
        chk("R8", active_src, 1);
        tick();
        chk("R8", {active_src, pri_ok, fast_ok, fast_osc_en}, {2'b00, 1'b1, 1'b0, 1'b0});

        // R5 slow source only: fast output never enabled
        drive(9'b10_000_0_0_0_0);
        repeat (STAB + 3) tick();
        chk("R5", {fast_osc_en, fast_ok, int_freq}, 5'b0);
        chk("R10", slow_rc_en, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule